// File: doc/BRIEF.md
# Command Slot Issue Scheduler

This block sits in one port of a storage host controller. It holds the port command register and the command-issue register, and it passes issued command slots one at a time to a downstream command engine. Software sets bits in the issue register to post work. While the port is started, the scheduler searches the posted slots from the lowest number upward and offers each one to the engine over a valid/ready handshake.

The engine answers every accepted slot in one of two ways. A done pulse means the command finished at once, and its issue bit is cleared. A raised busy level means the command is still running. In that case the slot is held as the single outstanding busy slot and its issue bit stays set. When the engine later drops its busy level, the held slot's bit is cleared and a fresh search starts at slot 0. The two running flags in the command register follow the start and receive-enable bits, and software cannot write them directly.

Top module: `cmd_slot_sched`

## Requirements
- R1: A write to the issue register ORs `wdata_i` into it. Writing a 0 bit never clears a set bit. Bits are cleared only by engine completion (R5, R7).
- R2: A slot is offered (`disp_valid_o`=1) only while command bit 0 (start) is 1, and only for a slot whose issue bit is set. With start at 0, no slot is offered however many bits are set.
- R3: Within one search, slots are offered in ascending order, lowest set bit first, with at most one offer per cycle. The search ends when no set bit remains at or above the current position.
- R4: While `eng_busy_i` is 1, or a busy slot is held, no slot is offered and the issue bits stay set. A search that meets this condition ends. Only a new trigger starts the next search: a write to either register, or the release of the busy slot.
- R5: If `eng_done_i` pulses after an accepted slot, that slot's issue bit is cleared and the search continues with the next higher set slot. A done pulse takes priority over busy in the same cycle.
- R6: If, after acceptance, the engine raises `eng_busy_i` without a done pulse, the slot number is held. `busy_vld_o`=1 and `busy_slot_o` shows the slot, and its issue bit stays set.
- R7: When a busy slot is held and `eng_busy_i` is 0, the held slot's issue bit is cleared, `busy_vld_o` returns to 0, and a new search starts from slot 0.
- R8: A command write stores `wdata_i` with bits 15 and 14 replaced. Bit 15 (list running) becomes written bit 0 (start), and bit 14 (receive running) becomes written bit 4 (receive enable).
- R9: After reset the command register reads 0x0000_0006 (bits 1 and 2 set), the issue register reads 0, `busy_vld_o`=0 and `disp_valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_wr_i | input | 1 | Write strobe for the command register |
| issue_wr_i | input | 1 | Write strobe for the issue register (OR semantics) |
| wdata_i | input | 32 | Write data for either register |
| cmd_o | output | 32 | Command register contents |
| issue_o | output | NUM_SLOTS | Issue register contents |
| disp_valid_o | output | 1 | A slot is offered to the engine |
| disp_slot_o | output | SLOT_W | Offered slot number |
| disp_ready_i | input | 1 | Engine accepts the offered slot |
| eng_done_i | input | 1 | Engine finished the accepted slot at once |
| eng_busy_i | input | 1 | Engine busy level |
| busy_vld_o | output | 1 | A busy slot is being held |
| busy_slot_o | output | SLOT_W | Held busy slot number |

## Verification
The bench builds the block with its default 32 slots and a 5-bit slot number, so the full-width issue mask and the topmost slot 31 are both reached. The longest single search, 32 back-to-back offers, therefore fits in one table entry. A bench engine model answers each accepted slot with either a done pulse or a held busy level, chosen per slot, and it can also hold the busy level before any dispatch. This covers the immediate-completion path, the held-slot path with rescan from 0, and the case where a search ends because the engine is busy.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  localparam int CMD_START_BIT = 0;
  localparam int CMD_SPIN_BIT  = 1;
  localparam int CMD_POWER_BIT = 2;
  localparam int CMD_FRE_BIT   = 4;
  localparam int CMD_FRUN_BIT  = 14;
  localparam int CMD_LRUN_BIT  = 15;

  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_SCAN = 2'd1,
    SC_WAIT = 2'd2
  } scan_state_e;
endpackage

// File: rtl/sched_cmd_reg.sv
module sched_cmd_reg
  import slot_sched_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cmd_o
);
  localparam logic [DATA_W-1:0] RST_VAL = (DATA_W'(1) << CMD_SPIN_BIT) | (DATA_W'(1) << CMD_POWER_BIT);

  logic [DATA_W-1:0] cmd_q, cmd_d;

  always_comb begin
    cmd_d = wdata_i;
    // running flags are status mirrors, never written directly
    cmd_d[CMD_LRUN_BIT] = wdata_i[CMD_START_BIT];
    cmd_d[CMD_FRUN_BIT] = wdata_i[CMD_FRE_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmd_q <= RST_VAL;
    else if (wr_i) cmd_q <= cmd_d;
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/sched_issue_reg.sv
module sched_issue_reg #(
  parameter int NUM_SLOTS = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [NUM_SLOTS-1:0] set_i,
  input  logic [NUM_SLOTS-1:0] clr_i,
  output logic [NUM_SLOTS-1:0] issue_o
);
  logic [NUM_SLOTS-1:0] issue_q;
  logic [NUM_SLOTS-1:0] set_m;

  assign set_m = wr_i ? set_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) issue_q <= '0;
    else         issue_q <= (issue_q & ~clr_i) | set_m; // new post wins over clear
  end

  assign issue_o = issue_q;
endmodule

// File: rtl/sched_slot_pick.sv
module sched_slot_pick #(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter int CUR_W     = SLOT_W + 1
) (
  input  logic [NUM_SLOTS-1:0] pend_i,
  input  logic [CUR_W-1:0]     cursor_i,
  output logic                 found_o,
  output logic [SLOT_W-1:0]    slot_o
);
  logic [NUM_SLOTS-1:0] cand;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cand
    assign cand[g] = pend_i[g] && (CUR_W'(g) >= cursor_i);
  end

  always_comb begin
    slot_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (cand[i]) slot_o = SLOT_W'(i);
    end
  end

  assign found_o = |cand;
endmodule

// File: rtl/sched_scan_ctrl.sv
module sched_scan_ctrl
  import slot_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter int CUR_W     = SLOT_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_wr_i,
  input  logic                 start_i,
  input  logic                 found_i,
  input  logic [SLOT_W-1:0]    pick_slot_i,
  input  logic                 disp_ready_i,
  input  logic                 eng_done_i,
  input  logic                 eng_busy_i,
  output logic                 disp_valid_o,
  output logic [SLOT_W-1:0]    disp_slot_o,
  output logic [CUR_W-1:0]     cursor_o,
  output logic [NUM_SLOTS-1:0] clr_o,
  output logic                 busy_vld_o,
  output logic [SLOT_W-1:0]    busy_slot_o
);
  scan_state_e       state_q;
  logic [CUR_W-1:0]  cursor_q;
  logic [SLOT_W-1:0] cur_slot_q, busy_slot_q;
  logic              restart_q, busy_vld_q;
  logic              release_evt, trig, can_disp, accept, wait_done;

  assign release_evt = busy_vld_q && !eng_busy_i;
  assign trig        = reg_wr_i || release_evt;
  assign can_disp    = (state_q == SC_SCAN) && !trig && start_i && !eng_busy_i
                       && !busy_vld_q && found_i;
  assign accept      = can_disp && disp_ready_i;
  assign wait_done   = (state_q == SC_WAIT) && eng_done_i;

  always_comb begin
    clr_o = '0;
    if (wait_done)   clr_o[cur_slot_q]  = 1'b1;
    if (release_evt) clr_o[busy_slot_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SC_IDLE;
      cursor_q    <= '0;
      cur_slot_q  <= '0;
      restart_q   <= 1'b0;
      busy_vld_q  <= 1'b0;
      busy_slot_q <= '0;
    end else begin
      if (release_evt) busy_vld_q <= 1'b0;
      unique case (state_q)
        SC_IDLE: begin
          if (trig) begin
            state_q  <= SC_SCAN;
            cursor_q <= '0;
          end
        end
        SC_SCAN: begin
          if (trig) begin
            cursor_q <= '0;
          end else if (!start_i || !found_i || eng_busy_i || busy_vld_q) begin
            state_q <= SC_IDLE;
          end else if (accept) begin
            state_q    <= SC_WAIT;
            cur_slot_q <= pick_slot_i;
            restart_q  <= 1'b0;
          end
        end
        SC_WAIT: begin
          if (trig) restart_q <= 1'b1;
          if (eng_done_i) begin
            state_q   <= SC_SCAN;
            cursor_q  <= (restart_q || trig) ? '0 : CUR_W'(cur_slot_q) + CUR_W'(1);
            restart_q <= 1'b0;
          end else if (eng_busy_i) begin
            busy_vld_q  <= 1'b1;
            busy_slot_q <= cur_slot_q;
            state_q     <= SC_IDLE;
            restart_q   <= 1'b0;
          end
        end
        default: state_q <= SC_IDLE;
      endcase
    end
  end

  assign disp_valid_o = can_disp;
  assign disp_slot_o  = pick_slot_i;
  assign cursor_o     = cursor_q;
  assign busy_vld_o   = busy_vld_q;
  assign busy_slot_o  = busy_slot_q;
endmodule

// File: rtl/cmd_slot_sched.sv
module cmd_slot_sched
  import slot_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int CUR_W    = SLOT_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_wr_i,
  input  logic                 issue_wr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    cmd_o,
  output logic [NUM_SLOTS-1:0] issue_o,
  output logic                 disp_valid_o,
  output logic [SLOT_W-1:0]    disp_slot_o,
  input  logic                 disp_ready_i,
  input  logic                 eng_done_i,
  input  logic                 eng_busy_i,
  output logic                 busy_vld_o,
  output logic [SLOT_W-1:0]    busy_slot_o
);
  logic [NUM_SLOTS-1:0] clr;
  logic [CUR_W-1:0]     cursor;
  logic                 found;
  logic [SLOT_W-1:0]    pick_slot;

  sched_cmd_reg #(.DATA_W(DATA_W)) u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cmd_wr_i),
    .wdata_i (wdata_i),
    .cmd_o   (cmd_o)
  );

  sched_issue_reg #(.NUM_SLOTS(NUM_SLOTS)) u_issue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (issue_wr_i),
    .set_i   (wdata_i[NUM_SLOTS-1:0]),
    .clr_i   (clr),
    .issue_o (issue_o)
  );

  sched_slot_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CUR_W(CUR_W)) u_pick (
    .pend_i   (issue_o),
    .cursor_i (cursor),
    .found_o  (found),
    .slot_o   (pick_slot)
  );

  sched_scan_ctrl #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CUR_W(CUR_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_wr_i     (cmd_wr_i || issue_wr_i),
    .start_i      (cmd_o[CMD_START_BIT]),
    .found_i      (found),
    .pick_slot_i  (pick_slot),
    .disp_ready_i (disp_ready_i),
    .eng_done_i   (eng_done_i),
    .eng_busy_i   (eng_busy_i),
    .disp_valid_o (disp_valid_o),
    .disp_slot_o  (disp_slot_o),
    .cursor_o     (cursor),
    .clr_o        (clr),
    .busy_vld_o   (busy_vld_o),
    .busy_slot_o  (busy_slot_o)
  );
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cmd_wr_i,
  input logic                 issue_wr_i,
  input logic                 wd_start_i,
  input logic                 wd_fre_i,
  input logic                 start_i,
  input logic                 lrun_i,
  input logic                 frun_i,
  input logic [NUM_SLOTS-1:0] issue_o,
  input logic                 disp_valid_o,
  input logic [SLOT_W-1:0]    disp_slot_o,
  input logic                 eng_done_i,
  input logic                 eng_busy_i,
  input logic                 busy_vld_o,
  input logic [SLOT_W-1:0]    busy_slot_o
);
  // R1
  no_lost_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eng_done_i && !busy_vld_o) |=> ((issue_o & $past(issue_o)) == $past(issue_o)));

  // R2
  offer_needs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> (start_i && issue_o[disp_slot_o]));

  // R4
  offer_engine_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> (!eng_busy_i && !busy_vld_o));

  // R7
  busy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_vld_o && !eng_busy_i && !issue_wr_i) |=> (!busy_vld_o && !issue_o[$past(busy_slot_o)]));

  // R8
  run_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i |=> (lrun_i == $past(wd_start_i) && frun_i == $past(wd_fre_i)));

  // R8
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_wr_i |=> ($stable(lrun_i) && $stable(frun_i)));
endmodule

bind cmd_slot_sched sched_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_wr_i     (cmd_wr_i),
  .issue_wr_i   (issue_wr_i),
  .wd_start_i   (wdata_i[slot_sched_pkg::CMD_START_BIT]),
  .wd_fre_i     (wdata_i[slot_sched_pkg::CMD_FRE_BIT]),
  .start_i      (cmd_o[slot_sched_pkg::CMD_START_BIT]),
  .lrun_i       (cmd_o[slot_sched_pkg::CMD_LRUN_BIT]),
  .frun_i       (cmd_o[slot_sched_pkg::CMD_FRUN_BIT]),
  .issue_o      (issue_o),
  .disp_valid_o (disp_valid_o),
  .disp_slot_o  (disp_slot_o),
  .eng_done_i   (eng_done_i),
  .eng_busy_i   (eng_busy_i),
  .busy_vld_o   (busy_vld_o),
  .busy_slot_o  (busy_slot_o)
);

// File: tb/sim_cmd_slot_sched.sv
module sim_cmd_slot_sched;
  localparam int NS = 32;
  localparam int NV = 6;
  localparam logic [31:0] VEC_MASK [NV] = '{32'h0000_0001, 32'h8000_0000, 32'h0000_00A5,
                                            32'hFFFF_FFFF, 32'h0001_0001, 32'h4000_0300};
  localparam int VEC_CNT [NV] = '{1, 1, 4, 32, 2, 3};

  logic        clk = 0, rst_n = 0;
  logic        cmd_wr = 0, issue_wr = 0;
  logic [31:0] wdata = '0;
  logic [31:0] cmd_o;
  logic [NS-1:0] issue_o;
  logic        disp_valid, disp_ready = 1, eng_done = 0, eng_busy = 0;
  logic [4:0]  disp_slot, busy_slot;
  logic        busy_vld;

  int tests = 0, fails = 0;
  bit finished = 0;
  int log_slot [64];
  int log_n = 0;
  bit rsp_pending = 0, hold = 0, hold_clear = 0, force_busy = 0;
  int rsp_slot = 0, busy_target = 99;

  always #2 clk = ~clk;

  cmd_slot_sched u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .issue_wr_i(issue_wr), .wdata_i(wdata),
    .cmd_o(cmd_o), .issue_o(issue_o), .disp_valid_o(disp_valid), .disp_slot_o(disp_slot),
    .disp_ready_i(disp_ready), .eng_done_i(eng_done), .eng_busy_i(eng_busy),
    .busy_vld_o(busy_vld), .busy_slot_o(busy_slot)
  );

  // engine model: answers one cycle after acceptance
  always begin
    @(negedge clk); #1;
    eng_done = 0;
    if (hold_clear) hold = 0;
    if (rsp_pending) begin
      rsp_pending = 0;
      if (rsp_slot == busy_target) hold = 1;
      else eng_done = 1;
    end
    eng_busy = hold | force_busy;
    if (disp_valid && disp_ready) begin
      if (log_n < 64) log_slot[log_n] = int'(disp_slot);
      log_n++;
      rsp_pending = 1;
      rsp_slot = int'(disp_slot);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [31:0] v);
    @(negedge clk); cmd_wr = 1; wdata = v;
    @(negedge clk); cmd_wr = 0; wdata = '0;
  endtask

  task automatic wr_issue(input logic [31:0] v);
    @(negedge clk); issue_wr = 1; wdata = v;
    @(negedge clk); issue_wr = 0; wdata = '0;
  endtask

  task automatic wait_drain();
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (issue_o == '0 && !disp_valid && !rsp_pending) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_order(input logic [31:0] mask, input string req);
    int idx = 0;
    bit ok = 1;
    int bad_a = 0, bad_e = 0;
    for (int b = 0; b < NS; b++) begin
      if (mask[b]) begin
        if (idx >= log_n || log_slot[idx] != b) begin
          if (ok) begin bad_a = (idx < log_n) ? log_slot[idx] : -1; bad_e = b; end
          ok = 0;
        end
        idx++;
      end
    end
    chk(ok, req, bad_a, bad_e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(cmd_o == 32'h6, "R9 cmd", cmd_o, 32'h6);
    chk(issue_o == '0, "R9 issue", issue_o, 0);
    chk(!disp_valid && !busy_vld, "R9 idle", {disp_valid, busy_vld}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    wr_cmd(32'h11);
    // R3 R5 table of masks
    for (int v = 0; v < NV; v++) begin
      log_n = 0;
      wr_issue(VEC_MASK[v]);
      wait_drain();
      chk(log_n == VEC_CNT[v], "R3 count", log_n, VEC_CNT[v]);
      chk_order(VEC_MASK[v], "R3 ascending order");
      chk(issue_o == '0, "R5 bits cleared", issue_o, 0);
    end

    // R1 R2 stopped port, OR semantics
    wr_cmd(32'h10);
    log_n = 0;
    wr_issue(32'h3);
    wr_issue(32'h4);
    wr_issue(32'h0);
    repeat (5) @(negedge clk);
    chk(issue_o == 32'h7, "R1 or-write", issue_o, 32'h7);
    chk(log_n == 0, "R2 no offer when stopped", log_n, 0);
    chk(cmd_o == 32'h4010, "R8 fre mirror", cmd_o, 32'h4010);

    // R8 running bits not writable; start triggers scan
    wr_cmd(32'h0000_C001);
    chk(cmd_o == 32'h8001, "R8 run bits", cmd_o, 32'h8001);
    wait_drain();
    chk_order(32'h7, "R2 offers after start");

    // R6 R7 busy slot
    busy_target = 1;
    log_n = 0;
    wr_issue(32'h7);
    repeat (10) @(negedge clk);
    chk(busy_vld && busy_slot == 5'd1, "R6 busy held", {busy_vld, busy_slot}, {1'b1, 5'd1});
    chk(issue_o == 32'h6, "R6 bit kept", issue_o, 32'h6);
    chk(log_n == 2, "R4 no offer while busy", log_n, 2);
    busy_target = 99;
    @(negedge clk); hold_clear = 1;
    @(negedge clk); hold_clear = 0;
    wait_drain();
    chk(!busy_vld, "R7 busy cleared", busy_vld, 0);
    chk(issue_o == '0, "R7 bits cleared", issue_o, 0);
    chk_order(32'h7, "R7 rescan");

    // R4 engine busy before dispatch ends the search
    force_busy = 1;
    log_n = 0;
    wr_issue(32'h8);
    repeat (6) @(negedge clk);
    chk(log_n == 0 && issue_o == 32'h8, "R4 blocked", log_n, 0);
    force_busy = 0;
    repeat (6) @(negedge clk);
    chk(log_n == 0, "R4 needs trigger", log_n, 0);
    wr_issue(32'h0);
    wait_drain();
    chk(log_n == 1 && log_slot[0] == 3, "R4 retrigger", log_slot[0], 3);
    chk(issue_o == '0, "R5 drained", issue_o, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule